// File: doc/BRIEF.md
# Chainable Stereo Gain Loader

This block is a write-only slave on a three-wire serial link (select, clock, data). It takes in a 16-bit word that holds two 8-bit gain codes for a stereo attenuator. A fast system clock samples the serial clock, the select and the data. The serial clock, select and data inputs first pass through a synchronizer. Edges of the serial clock and of the select line are then detected in the system clock domain.

Every bit that falls off the end of the internal 16-bit register is presented again on a serial output. That output changes on the falling serial clock edge. Any number of units can therefore be chained, output to input, under one select line and one serial clock. Such a chain acts as a single register of 16 bits per unit.

The gain codes change only when the select line is released. At that point both codes are taken from the register at once, and a single-cycle strobe marks that new codes are present.

Top module: `gain_serial_port`

## Requirements
- R1: After reset, both gain codes are 0x00, the update strobe is low and the serial output enable is low.
- R2: Serial clock rising edges that occur while the select input `cs_ni` is high do not shift data into the register.
- R3: Data is captured on rising serial clock edges and sent most significant bit first. The first 8 bits received form the right gain code (bit 7 first), and the next 8 bits form the left gain code.
- R4: The serial output enable is high while the select is low and low while the select is high. When it is low, the serial output holds its value.
- R5: On each falling serial clock edge inside a frame, the serial output takes the register's top bit. As a result, the first bit written appears after 16 clocks.
- R6: The gain codes change only in the cycle in which the update strobe is high. They never change while a frame is in progress.
- R7: Each rising edge of the select input produces exactly one update strobe, and that strobe is one system clock wide.
- R8: A frame with fewer than 16 serial clocks still commits the register contents, including bits left over from earlier frames.
- R9: In a chain of three units driven by a 48-bit frame, the last unit receives the first 16 bits and the first unit receives the last 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock. It must run at 4 times the serial clock rate or faster. |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Frame select, active low |
| sclk_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out, feeds the next unit |
| sdo_oe_o | output | 1 | Drive enable for sdo_o. When it is low, the pad is left floating. |
| right_gain_o | output | 8 | Committed right channel gain code |
| left_gain_o | output | 8 | Committed left channel gain code |
| update_o | output | 1 | One-cycle strobe that marks new gain codes |

## Verification
The bound checker watches four rules on every cycle. Gain codes stay put outside the update strobe, and the strobe never lasts two cycles. The serial output is frozen while it is not enabled, and no strobe is raised while the output is enabled.

Three properties depend on whole frames, so only the bench scenarios can show them:
- the bit order and the split of each word into right and left codes;
- that serial clocks with the select high are ignored;
- the contents committed after a short frame, and the slice each unit of a three-unit chain latches from a 48-bit stream.

A reference chain model in the scoreboard checks these cases.

// File: rtl/gsp_pkg.sv
package gsp_pkg;
  localparam int unsigned GAIN_W = 8;
  localparam int unsigned WORD_W = 2 * GAIN_W;

  typedef struct packed {
    logic [GAIN_W-1:0] right;
    logic [GAIN_W-1:0] left;
  } gain_pair_t;
endpackage

// File: rtl/gsp_sync.sv
module gsp_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] src;
    if (s == 0) begin : g_first
      assign src = d_i;
    end else begin : g_next
      assign src = stage_q[s-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= RST_VAL;
      else         stage_q[s] <= src;
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gsp_front.sv
module gsp_front #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sclk_i,
  input  logic sdi_i,
  output logic sclk_rise_o,
  output logic sclk_fall_o,
  output logic cs_active_o,
  output logic cs_rise_o,
  output logic sdi_o
);
  // bit order: {cs, sclk, sdi}; cs resets high (idle)
  localparam logic [2:0] RST_VAL = 3'b100;

  logic [2:0] raw, synced;
  logic       cs_prev_q, sclk_prev_q;

  assign raw = {cs_ni, sclk_i, sdi_i};

  gsp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(RST_VAL)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (synced)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_prev_q   <= 1'b1;
      sclk_prev_q <= 1'b0;
    end else begin
      cs_prev_q   <= synced[2];
      sclk_prev_q <= synced[1];
    end
  end

  assign cs_active_o = ~synced[2];
  assign cs_rise_o   = synced[2] & ~cs_prev_q;
  assign sclk_rise_o = synced[1] & ~sclk_prev_q;
  assign sclk_fall_o = ~synced[1] & sclk_prev_q;
  assign sdi_o       = synced[0];
endmodule

// File: rtl/gsp_shifter.sv
module gsp_shifter
  import gsp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              emit_i,
  input  logic              bit_i,
  output logic [WORD_W-1:0] word_o,
  output logic              sdo_o
);
  logic [WORD_W-1:0] sh_q;
  logic              sdo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      sdo_q <= 1'b0;
    end else begin
      if (shift_i) sh_q  <= {sh_q[WORD_W-2:0], bit_i};
      // retimed to the falling edge so the next unit samples a stable bit
      if (emit_i)  sdo_q <= sh_q[WORD_W-1];
    end
  end

  assign word_o = sh_q;
  assign sdo_o  = sdo_q;
endmodule

// File: rtl/gsp_commit.sv
module gsp_commit
  import gsp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  output gain_pair_t        gains_o,
  output logic              update_o
);
  gain_pair_t gains_q;
  logic       upd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gains_q <= '0;
      upd_q   <= 1'b0;
    end else begin
      upd_q <= load_i;
      if (load_i) gains_q <= gain_pair_t'(word_i);
    end
  end

  assign gains_o  = gains_q;
  assign update_o = upd_q;
endmodule

// File: rtl/gain_serial_port.sv
module gain_serial_port
  import gsp_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic [GAIN_W-1:0] right_gain_o,
  output logic [GAIN_W-1:0] left_gain_o,
  output logic              update_o
);
  logic              sclk_rise, sclk_fall, cs_active, cs_rise, sdi_s;
  logic [WORD_W-1:0] word;
  gain_pair_t        gains;

  gsp_front #(.SYNC_STAGES(SYNC_STAGES)) i_front (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_ni      (cs_ni),
    .sclk_i     (sclk_i),
    .sdi_i      (sdi_i),
    .sclk_rise_o(sclk_rise),
    .sclk_fall_o(sclk_fall),
    .cs_active_o(cs_active),
    .cs_rise_o  (cs_rise),
    .sdi_o      (sdi_s)
  );

  gsp_shifter i_shifter (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .shift_i(sclk_rise & cs_active),
    .emit_i (sclk_fall & cs_active),
    .bit_i  (sdi_s),
    .word_o (word),
    .sdo_o  (sdo_o)
  );

  gsp_commit i_commit (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (cs_rise),
    .word_i  (word),
    .gains_o (gains),
    .update_o(update_o)
  );

  assign sdo_oe_o     = cs_active;
  assign right_gain_o = gains.right;
  assign left_gain_o  = gains.left;
endmodule

// File: rtl/gain_serial_port_chk.sv
module gain_serial_port_chk
  import gsp_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sdo_o,
  input logic              sdo_oe_o,
  input logic [GAIN_W-1:0] right_gain_o,
  input logic [GAIN_W-1:0] left_gain_o,
  input logic              update_o
);
  a_r6_gain_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !update_o |-> $stable({right_gain_o, left_gain_o}));

  a_r7_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_o |=> !update_o);

  a_r4_sdo_frozen_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sdo_oe_o |=> $stable(sdo_o));

  a_r7_strobe_after_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_o |-> !sdo_oe_o);
endmodule

bind gain_serial_port gain_serial_port_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sdo_o       (sdo_o),
  .sdo_oe_o    (sdo_oe_o),
  .right_gain_o(right_gain_o),
  .left_gain_o (left_gain_o),
  .update_o    (update_o)
);

// File: tb/test_gain_serial_port.sv
module test_gain_serial_port;
  localparam int NDEV = 3;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;

  logic       sdo [NDEV];
  logic       oe  [NDEV];
  logic       upd [NDEV];
  logic [7:0] rg  [NDEV];
  logic [7:0] lg  [NDEV];
  logic       din [NDEV];

  int checks = 0, fails = 0;
  logic [47:0] model = '0;       // dev k register = model[16k+15:16k]
  logic [47:0] exp_q[$];
  logic [15:0] last_cmt [NDEV];

  always #10 clk = ~clk;         // 50 MHz

  for (genvar k = 0; k < NDEV; k++) begin : g_dev
    if (k == 0) begin : g_head
      assign din[k] = sdi;
    end else begin : g_tail
      assign din[k] = sdo[k-1];
    end
    gain_serial_port i_gain_serial_port (
      .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .sdi_i(din[k]),
      .sdo_o(sdo[k]), .sdo_oe_o(oe[k]), .right_gain_o(rg[k]), .left_gain_o(lg[k]),
      .update_o(upd[k]));
  end

  task automatic check(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // shift n bits from the top of data (MSB first) in one frame
  task automatic frame(input logic [47:0] data, input int n);
    cs_n = 1'b0;
    wait_clk(HALF);
    check(oe[0] && oe[2], "R4 enable in frame", {oe[0], oe[2]}, 2'b11);
    for (int i = 0; i < n; i++) begin
      sclk = 1'b0;
      sdi  = data[47-i];
      wait_clk(HALF);
      if (i >= 1) check(sdo[0] == model[15], "R5 sdo top bit", sdo[0], model[15]);
      sclk = 1'b1;
      model = {model[46:0], data[47-i]};
      wait_clk(HALF);
    end
    sclk = 1'b0;
    wait_clk(HALF);
    exp_q.push_back(model);
    cs_n = 1'b1;
    wait_clk(4 * HALF);
    check(!oe[0], "R4 released", oe[0], 1'b0);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      for (int k = 0; k < NDEV; k++)
        if (!upd[k] && {rg[k], lg[k]} != last_cmt[k]) begin
          fails++;
          $display("FAIL R6 mid-frame change dev%0d: actual %h expected %h", k, {rg[k], lg[k]}, last_cmt[k]);
        end
      if (upd[0] || upd[1] || upd[2]) begin
        logic [47:0] e;
        check(upd[0] && upd[1] && upd[2], "R7 common strobe", {upd[0], upd[1], upd[2]}, 3'b111);
        if (exp_q.size() == 0) begin
          check(1'b0, "R7 unexpected strobe", 48'h1, 48'h0);
        end else begin
          e = exp_q.pop_front();
          for (int k = 0; k < NDEV; k++) begin
            check({rg[k], lg[k]} == e[16*k +: 16], "R3/R9 committed gains",
                  {rg[k], lg[k]}, e[16*k +: 16]);
            last_cmt[k] = e[16*k +: 16];
          end
        end
      end
    end
  end

  initial begin
    for (int k = 0; k < NDEV; k++) last_cmt[k] = '0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    // R1 reset state
    check(rg[0] == 0 && lg[0] == 0, "R1 gains zero", {rg[0], lg[0]}, 16'h0);
    check(!upd[0] && !oe[0], "R1 strobe/enable low", {upd[0], oe[0]}, 2'b00);

    // R3 single word: right A5, left 3C
    frame({16'hA53C, 32'h0}, 16);
    check(rg[0] == 8'hA5, "R3 right byte first", rg[0], 8'hA5);
    check(lg[0] == 8'h3C, "R3 left byte second", lg[0], 8'h3C);

    // R2 clocks with select high are ignored, then an empty frame recommits
    sdi = 1'b1;
    for (int i = 0; i < 16; i++) begin
      sclk = 1'b1; wait_clk(HALF); sclk = 1'b0; wait_clk(HALF);
    end
    frame(48'h0, 0);
    check(rg[0] == 8'hA5 && lg[0] == 8'h3C, "R2 idle clocks ignored", {rg[0], lg[0]}, 16'hA53C);

    // R9 chain of three: 48-bit stream
    frame(48'h1122_3344_5566, 48);
    check({rg[2], lg[2]} == 16'h1122, "R9 last unit gets first slice", {rg[2], lg[2]}, 16'h1122);
    check({rg[1], lg[1]} == 16'h3344, "R9 middle slice", {rg[1], lg[1]}, 16'h3344);
    check({rg[0], lg[0]} == 16'h5566, "R9 first unit gets last slice", {rg[0], lg[0]}, 16'h5566);

    // R8 short frame of 4 bits: 0x5566 -> 0x566B
    frame({4'hB, 44'h0}, 4);
    check({rg[0], lg[0]} == 16'h566B, "R8 short frame", {rg[0], lg[0]}, 16'h566B);

    // patterns across the full code range
    frame({16'hFF00, 32'h0}, 16);
    frame({16'h00FF, 32'h0}, 16);
    frame({16'h8001, 32'h0}, 16);

    wait_clk(20);
    check(exp_q.size() == 0, "R7 one strobe per frame", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule